// File: doc/BRIEF.md
# Tile Integer Matrix Multiply-Accumulate Sequencer

The block holds three small tiles in internal registers: a first source A, a second source B and an accumulator C. Each tile row is a run of 32-bit lanes, and each lane packs four 8-bit elements. After one start pulse the block computes C += A × B. Each C lane accumulates the four-byte dot products of the matching A lanes and B lanes in 32-bit two's-complement arithmetic, so a sum that overflows wraps.

The configuration inputs set the number of C rows and the bytes per row of A and C. The element count of a tile is its bytes divided by four. The sequencer walks the C rows in the outer loop, the A lanes (k) in the middle loop and the C lanes (n) in the inner loop, with one dot product per cycle. For each row it copies the row into a working register, updates that register, and writes it back with the lanes past the configured width forced to zero. When the last configured row is done, one more cycle clears every C row at or beyond the configured row count.

A two-bit mode input selects whether each source is signed. A host port loads the tiles and reads them back, one lane at a time.

Top module: `tmac_top`

## Requirements
- R1: When an operation ends, every C lane n in a row m below the configured row count, with n below c_bytes/4, equals its old value plus the sum over k below a_bytes/4 of the four byte products of A[m][k] and B[k][n], taken modulo 2^32. The byte at bits 8i+7:8i of one lane pairs with the byte at the same position of the other lane.
- R2: `mode` bit 1 set makes the A bytes signed, and clear makes them unsigned. Bit 0 does the same for the B bytes. The block samples the mode at the accepted start and ignores later changes to it during the operation.
- R3: In each C row below the configured row count, every lane at or above c_bytes/4 reads zero after the operation. A c_bytes of 0 zeroes the whole row.
- R4: After the operation, every C row at or beyond the configured row count reads zero.
- R5: With a_bytes of 0, the C lanes inside the configured width keep their old values, and R3 and R4 still apply.
- R6: The block rejects a start when cfg_rows exceeds the tile row count, when either byte count exceeds the row bytes, or when either byte count is not a multiple of 4. On a rejected start, `done` and `err` are both high in the next cycle, `busy` stays low and no tile changes.
- R7: After an accepted start, `busy` is high from the next cycle until `done` rises. `done` is high for exactly one cycle, and `busy` is low while `done` is high. `err` is high only together with `done`.
- R8: The block acts on `start` only while both `busy` and `done` are low. A start pulse, a new configuration or a new mode during an operation has no effect on the result.
- R9: The host port selects the tile with `host_sel` (0 = A, 1 = B, 2 = C), and the row and lane with `host_row` and `host_lane`. `host_rdata` shows the selected lane in the same cycle. A write takes effect at the next clock edge, except that the block ignores writes while `busy` is high.
- R10: An operation leaves the A and B tiles unchanged. After reset, every tile lane reads zero, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation request |
| mode | input | 2 | Bit 1: A signed, bit 0: B signed |
| cfg_rows | input | 3 | Number of C rows to compute (0 to 4) |
| cfg_a_bytes | input | 5 | Bytes per row of A (multiple of 4, up to 16) |
| cfg_c_bytes | input | 5 | Bytes per row of C (multiple of 4, up to 16) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Configuration rejected, valid with done |
| host_we | input | 1 | Host lane write enable |
| host_sel | input | 2 | Tile select |
| host_row | input | 2 | Row index |
| host_lane | input | 2 | Lane index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected lane |

## Verification
The bench sweeps all four signedness modes against row counts of 0, 1, 3 and 4, A widths of 0, 4, 8 and 16 bytes, and C widths of 0, 4, 12 and 16 bytes. This separates the loop bounds, the lane masking and the row clearing. Pseudo-random data alternates with extreme bytes (0x80, 0x7F, 0xFF). The extreme bytes produce different sums under each sign interpretation and push the accumulators through wrap-around. Separate runs send rejected configurations, a second start and changed inputs during a run, and a host write while busy, and each must leave the tiles exactly where the arithmetic model expects.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

    localparam int unsigned LANE_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LANE_BYTES = LANE_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_WRITE,
        ST_CLEAR,
        ST_FIN
    } tmac_state_e;

    typedef struct packed {
        logic a_signed;
        logic b_signed;
    } tmac_mode_t;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2
    } tmac_sel_e;

    // Four-byte dot product; each byte is widened to 9 bits, signed or zero extended.
    function automatic logic [LANE_W-1:0] dot4(
        input logic [LANE_W-1:0] a,
        input logic [LANE_W-1:0] b,
        input tmac_mode_t        md
    );
        logic signed [LANE_W-1:0] acc;
        logic signed [8:0]        ea;
        logic signed [8:0]        eb;
        acc = '0;
        for (int i = 0; i < int'(LANE_BYTES); i++) begin
            ea  = {md.a_signed & a[BYTE_W*i+7], a[BYTE_W*i +: BYTE_W]};
            eb  = {md.b_signed & b[BYTE_W*i+7], b[BYTE_W*i +: BYTE_W]};
            acc = acc + ea * eb;
        end
        return acc;
    endfunction

endpackage

// File: rtl/tmac_tile_store.sv
module tmac_tile_store
    import tmac_pkg::*;
#(
    parameter int unsigned ROWS  = 4,
    parameter int unsigned LANES = 4,
    parameter int unsigned RW    = 2,
    parameter int unsigned LW    = 2,
    parameter int unsigned CW    = 3,
    parameter int unsigned HRW   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  logic [1:0]              host_sel,
    input  logic [HRW-1:0]          host_row,
    input  logic [LW-1:0]           host_lane,
    input  logic [LANE_W-1:0]       host_wdata,
    output logic [LANE_W-1:0]       host_rdata,
    input  logic [RW-1:0]           a_row,
    input  logic [LW-1:0]           a_lane,
    output logic [LANE_W-1:0]       a_data,
    input  logic [LW-1:0]           b_row,
    input  logic [LW-1:0]           b_lane,
    output logic [LANE_W-1:0]       b_data,
    input  logic [RW-1:0]           c_row,
    output logic [LANES*LANE_W-1:0] c_row_data,
    input  logic                    c_wr_en,
    input  logic [LANES*LANE_W-1:0] c_wr_data,
    input  logic                    c_clr_en,
    input  logic [CW-1:0]           c_clr_from
);

    logic [LANE_W-1:0] a_mem [ROWS][LANES];
    logic [LANE_W-1:0] b_mem [LANES][LANES];
    logic [LANE_W-1:0] c_mem [ROWS][LANES];

    logic a_row_ok;
    logic b_row_ok;
    assign a_row_ok = 32'(host_row) < ROWS;
    assign b_row_ok = 32'(host_row) < LANES;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < int'(ROWS); r++) begin
                for (int l = 0; l < int'(LANES); l++) begin
                    a_mem[r][l] <= '0;
                    c_mem[r][l] <= '0;
                end
            end
            for (int r = 0; r < int'(LANES); r++) begin
                for (int l = 0; l < int'(LANES); l++) begin
                    b_mem[r][l] <= '0;
                end
            end
        end else begin
            if (host_we) begin
                unique case (host_sel)
                    SEL_A: if (a_row_ok) a_mem[host_row[RW-1:0]][host_lane] <= host_wdata;
                    SEL_B: if (b_row_ok) b_mem[host_row[LW-1:0]][host_lane] <= host_wdata;
                    SEL_C: if (a_row_ok) c_mem[host_row[RW-1:0]][host_lane] <= host_wdata;
                    default: ;
                endcase
            end
            if (c_wr_en) begin
                for (int l = 0; l < int'(LANES); l++) begin
                    c_mem[c_row][l] <= c_wr_data[l*LANE_W +: LANE_W];
                end
            end
            if (c_clr_en) begin
                for (int r = 0; r < int'(ROWS); r++) begin
                    if (CW'(r) >= c_clr_from) begin
                        for (int l = 0; l < int'(LANES); l++) begin
                            c_mem[r][l] <= '0;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_A: if (a_row_ok) host_rdata = a_mem[host_row[RW-1:0]][host_lane];
            SEL_B: if (b_row_ok) host_rdata = b_mem[host_row[LW-1:0]][host_lane];
            SEL_C: if (a_row_ok) host_rdata = c_mem[host_row[RW-1:0]][host_lane];
            default: host_rdata = '0;
        endcase
    end

    assign a_data = a_mem[a_row][a_lane];
    assign b_data = b_mem[b_row][b_lane];

    for (genvar g = 0; g < LANES; g++) begin : g_crow
        assign c_row_data[g*LANE_W +: LANE_W] = c_mem[c_row][g];
    end

    AST_HOST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        !(host_we && (c_wr_en || c_clr_en))); // R9

endmodule

// File: rtl/tmac_row_acc.sv
module tmac_row_acc
    import tmac_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned LW    = 2,
    parameter int unsigned LEW   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic [LANES*LANE_W-1:0] row_in,
    input  logic                    step_en,
    input  logic [LW-1:0]           n_idx,
    input  logic [LANE_W-1:0]       a_lane,
    input  logic [LANE_W-1:0]       b_lane,
    input  tmac_mode_t              mode,
    input  logic [LEW-1:0]          c_el,
    output logic [LANES*LANE_W-1:0] row_out
);

    logic [LANE_W-1:0] work [LANES];
    logic [LANE_W-1:0] prod;

    assign prod = dot4(a_lane, b_lane, mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < int'(LANES); l++) work[l] <= '0;
        end else if (load_en) begin
            for (int l = 0; l < int'(LANES); l++) work[l] <= row_in[l*LANE_W +: LANE_W];
        end else if (step_en) begin
            work[n_idx] <= work[n_idx] + prod;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign row_out[g*LANE_W +: LANE_W] = (LEW'(g) < c_el) ? work[g] : '0;
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (step_en && $past(step_en)) |-> $stable(mode)); // R2

endmodule

// File: rtl/tmac_seq.sv
module tmac_seq
    import tmac_pkg::*;
#(
    parameter int unsigned ROWS      = 4,
    parameter int unsigned ROW_BYTES = 16,
    parameter int unsigned CW        = 3,
    parameter int unsigned BW        = 5,
    parameter int unsigned LEW       = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [1:0]     mode_in,
    input  logic [CW-1:0]  cfg_rows,
    input  logic [BW-1:0]  cfg_a_bytes,
    input  logic [BW-1:0]  cfg_c_bytes,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic           load_en,
    output logic           step_en,
    output logic           wr_en,
    output logic           clr_en,
    output logic [CW-1:0]  m_idx,
    output logic [LEW-1:0] k_idx,
    output logic [LEW-1:0] n_idx,
    output logic [CW-1:0]  rows_q,
    output logic [LEW-1:0] c_el_q,
    output tmac_mode_t     mode_q
);

    localparam logic [LEW-1:0] ONE_E = LEW'(1);
    localparam logic [CW-1:0]  ONE_R = CW'(1);

    tmac_state_e    state;
    logic [LEW-1:0] a_el_q;
    logic           err_q;
    logic           cfg_ok;

    assign cfg_ok = (cfg_rows <= CW'(ROWS))
                 && (cfg_a_bytes <= BW'(ROW_BYTES))
                 && (cfg_c_bytes <= BW'(ROW_BYTES))
                 && (cfg_a_bytes[1:0] == 2'b00)
                 && (cfg_c_bytes[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            m_idx  <= '0;
            k_idx  <= '0;
            n_idx  <= '0;
            rows_q <= '0;
            a_el_q <= '0;
            c_el_q <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    err_q <= 1'b0;
                    if (start) begin
                        if (cfg_ok) begin
                            rows_q <= cfg_rows;
                            a_el_q <= LEW'(cfg_a_bytes >> 2);
                            c_el_q <= LEW'(cfg_c_bytes >> 2);
                            mode_q <= tmac_mode_t'(mode_in);
                            m_idx  <= '0;
                            state  <= (cfg_rows == '0) ? ST_CLEAR : ST_LOAD;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_FIN;
                        end
                    end
                end
                ST_LOAD: begin
                    k_idx <= '0;
                    n_idx <= '0;
                    state <= (a_el_q == '0 || c_el_q == '0) ? ST_WRITE : ST_STEP;
                end
                ST_STEP: begin
                    if (n_idx == c_el_q - ONE_E) begin
                        n_idx <= '0;
                        if (k_idx == a_el_q - ONE_E) state <= ST_WRITE;
                        else                         k_idx <= k_idx + ONE_E;
                    end else begin
                        n_idx <= n_idx + ONE_E;
                    end
                end
                ST_WRITE: begin
                    m_idx <= m_idx + ONE_R;
                    state <= (m_idx + ONE_R == rows_q) ? ST_CLEAR : ST_LOAD;
                end
                ST_CLEAR: state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_LOAD) || (state == ST_STEP) ||
                     (state == ST_WRITE) || (state == ST_CLEAR);
    assign done    = (state == ST_FIN);
    assign err     = done && err_q;
    assign load_en = (state == ST_LOAD);
    assign step_en = (state == ST_STEP);
    assign wr_en   = (state == ST_WRITE);
    assign clr_en  = (state == ST_CLEAR);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && cfg_ok) |=> busy); // R7
    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && !cfg_ok) |=> (done && err && !busy)); // R6
    AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (k_idx < a_el_q && n_idx < c_el_q && m_idx < rows_q)); // R1

endmodule

// File: rtl/tmac_top.sv
module tmac_top
    import tmac_pkg::*;
#(
    parameter int unsigned ROWS      = 4,
    parameter int unsigned ROW_BYTES = 16,
    localparam int unsigned LANES    = ROW_BYTES / LANE_BYTES,
    localparam int unsigned RW       = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned LW       = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned HRW      = (RW > LW) ? RW : LW,
    localparam int unsigned CW       = $clog2(ROWS + 1),
    localparam int unsigned BW       = $clog2(ROW_BYTES + 1),
    localparam int unsigned LEW      = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [CW-1:0]     cfg_rows,
    input  logic [BW-1:0]     cfg_a_bytes,
    input  logic [BW-1:0]     cfg_c_bytes,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [HRW-1:0]    host_row,
    input  logic [LW-1:0]     host_lane,
    input  logic [LANE_W-1:0] host_wdata,
    output logic [LANE_W-1:0] host_rdata
);

    logic                    load_en, step_en, wr_en, clr_en;
    logic [CW-1:0]           m_idx, rows_q;
    logic [LEW-1:0]          k_idx, n_idx, c_el_q;
    tmac_mode_t              mode_q;
    logic [LANE_W-1:0]       a_data, b_data;
    logic [LANES*LANE_W-1:0] c_row_data, c_wr_data;

    tmac_seq #(
        .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .CW(CW), .BW(BW), .LEW(LEW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode),
        .cfg_rows(cfg_rows), .cfg_a_bytes(cfg_a_bytes), .cfg_c_bytes(cfg_c_bytes),
        .busy(busy), .done(done), .err(err),
        .load_en(load_en), .step_en(step_en), .wr_en(wr_en), .clr_en(clr_en),
        .m_idx(m_idx), .k_idx(k_idx), .n_idx(n_idx),
        .rows_q(rows_q), .c_el_q(c_el_q), .mode_q(mode_q)
    );

    tmac_tile_store #(
        .ROWS(ROWS), .LANES(LANES), .RW(RW), .LW(LW), .CW(CW), .HRW(HRW)
    ) u_store (
        .clk(clk), .rst(rst),
        .host_we(host_we && !busy), .host_sel(host_sel), .host_row(host_row),
        .host_lane(host_lane), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .a_row(m_idx[RW-1:0]), .a_lane(k_idx[LW-1:0]), .a_data(a_data),
        .b_row(k_idx[LW-1:0]), .b_lane(n_idx[LW-1:0]), .b_data(b_data),
        .c_row(m_idx[RW-1:0]), .c_row_data(c_row_data),
        .c_wr_en(wr_en), .c_wr_data(c_wr_data),
        .c_clr_en(clr_en), .c_clr_from(rows_q)
    );

    tmac_row_acc #(
        .LANES(LANES), .LW(LW), .LEW(LEW)
    ) u_acc (
        .clk(clk), .rst(rst),
        .load_en(load_en), .row_in(c_row_data),
        .step_en(step_en), .n_idx(n_idx[LW-1:0]),
        .a_lane(a_data), .b_lane(b_data), .mode(mode_q),
        .c_el(c_el_q), .row_out(c_wr_data)
    );

endmodule

// File: tb/tb_tmac_top.sv
module tb_tmac_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  mode;
    logic [2:0]  cfg_rows;
    logic [4:0]  cfg_a_bytes;
    logic [4:0]  cfg_c_bytes;
    logic        busy, done, err;
    logic        host_we;
    logic [1:0]  host_sel;
    logic [1:0]  host_row;
    logic [1:0]  host_lane;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [31:0] ma [4][4];
    logic [31:0] mb [4][4];
    logic [31:0] mc [4][4];

    always #5 clk = ~clk;

    tmac_top dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .cfg_rows(cfg_rows), .cfg_a_bytes(cfg_a_bytes), .cfg_c_bytes(cfg_c_bytes),
        .busy(busy), .done(done), .err(err),
        .host_we(host_we), .host_sel(host_sel), .host_row(host_row),
        .host_lane(host_lane), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic int ext(input logic [7:0] v, input logic s);
        return s ? int'($signed(v)) : int'(v);
    endfunction

    task automatic wr(input logic [1:0] s, input int r, input int l, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_row = 2'(r); host_lane = 2'(l); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input int r, input int l, output logic [31:0] d);
        host_sel = s; host_row = 2'(r); host_lane = 2'(l);
        #1;
        d = host_rdata;
    endtask

    task automatic load_tiles(input int pat);
        logic [31:0] v;
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 4; l++) begin
                v = (pat == 1) ? 32'h80FF_7F80 : (pat == 2) ? 32'h7F80_80FF : rnd();
                ma[r][l] = v; wr(2'd0, r, l, v);
                v = (pat == 1) ? 32'hFF80_FF7F : (pat == 2) ? 32'hFFFF_FFFF : rnd();
                mb[r][l] = v; wr(2'd1, r, l, v);
                v = (pat == 2) ? 32'h7FFF_FF00 : rnd();
                mc[r][l] = v; wr(2'd2, r, l, v);
            end
        end
    endtask

    // Arithmetic model of R1-type accumulation, masking and clearing.
    task automatic model(input logic [1:0] md, input int rows, input int ab, input int cb);
        int acc;
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < 4; n++) begin
                if (r >= rows || n >= cb / 4) begin
                    mc[r][n] = '0;
                end else begin
                    acc = int'(mc[r][n]);
                    for (int k = 0; k < ab / 4; k++)
                        for (int b = 0; b < 4; b++)
                            acc += ext(ma[r][k][8*b +: 8], md[1]) * ext(mb[k][n][8*b +: 8], md[0]);
                    mc[r][n] = 32'(acc);
                end
            end
        end
    endtask

    task automatic check_tiles(input int rows, input int ab, input int cb, input string tag);
        logic [31:0] d;
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 4; l++) begin
                rd(2'd2, r, l, d);
                if (r >= rows)           check("R4", tag, d, mc[r][l]);
                else if (l >= cb / 4)    check("R3", tag, d, mc[r][l]);
                else if (ab == 0)        check("R5", tag, d, mc[r][l]);
                else                     check("R1 R2", tag, d, mc[r][l]);
                rd(2'd0, r, l, d); check("R10", {tag, " A kept"}, d, ma[r][l]);
                rd(2'd1, r, l, d); check("R10", {tag, " B kept"}, d, mb[r][l]);
            end
        end
    endtask

    // Pulse start; disturb = 1 pulses start again, changes config/mode and tries a host write mid-run.
    task automatic run_op(input logic [1:0] md, input int rows, input int ab, input int cb,
                          input bit bad, input bit disturb);
        int wait_n;
        @(negedge clk);
        start = 1'b1; mode = md; cfg_rows = 3'(rows); cfg_a_bytes = 5'(ab); cfg_c_bytes = 5'(cb);
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            check("R6", "reject done", {31'd0, done}, 32'd1);
            check("R6", "reject err", {31'd0, err}, 32'd1);
            check("R6", "reject busy low", {31'd0, busy}, 32'd0);
        end else begin
            check("R7", "busy after start", {31'd0, busy}, 32'd1);
            check("R7", "no early done", {31'd0, done}, 32'd0);
            if (disturb) begin
                start = 1'b1; mode = ~md; cfg_rows = 3'd1; cfg_a_bytes = 5'd4; cfg_c_bytes = 5'd4;
                host_we = 1'b1; host_sel = 2'd0; host_row = 2'd0; host_lane = 2'd0;
                host_wdata = ~ma[0][0];
                @(negedge clk);
                start = 1'b0; host_we = 1'b0;
            end
            wait_n = 0;
            while (!done && wait_n < 1000) begin
                @(negedge clk);
                wait_n++;
            end
            check("R7", "done seen", {31'd0, done}, 32'd1);
            check("R7", "busy low with done", {31'd0, busy}, 32'd0);
            check("R7", "no err", {31'd0, err}, 32'd0);
        end
        @(negedge clk);
        check("R7", "done one cycle", {31'd0, done}, 32'd0);
        mode = 2'd0;
    endtask

    initial begin
        logic [31:0] d;
        int rl [4];
        int al [4];
        int cl [4];
        int run;
        rl = '{0, 1, 3, 4};
        al = '{0, 4, 8, 16};
        cl = '{0, 4, 12, 16};
        rst = 1'b1; start = 1'b0; mode = 2'd0; cfg_rows = '0; cfg_a_bytes = '0; cfg_c_bytes = '0;
        host_we = 1'b0; host_sel = '0; host_row = '0; host_lane = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "reset busy", {31'd0, busy}, 32'd0);
        check("R10", "reset done", {31'd0, done}, 32'd0);
        check("R10", "reset err", {31'd0, err}, 32'd0);
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 4; r++)
                for (int l = 0; l < 4; l++) begin
                    rd(2'(s), r, l, d);
                    check("R10", "reset tile", d, 32'd0);
                end

        // R9: write then read back through host port
        wr(2'd2, 1, 2, 32'hCAFE_F00D);
        rd(2'd2, 1, 2, d);
        check("R9", "host readback", d, 32'hCAFE_F00D);

        run = 0;
        for (int md = 0; md < 4; md++)
            for (int ri = 0; ri < 4; ri++)
                for (int ai = 0; ai < 4; ai++)
                    for (int ci = 0; ci < 4; ci++) begin
                        load_tiles(run % 3);
                        run_op(2'(md), rl[ri], al[ai], cl[ci], 1'b0, 1'b0);
                        model(2'(md), rl[ri], al[ai], cl[ci]);
                        check_tiles(rl[ri], al[ai], cl[ci], "sweep");
                        run++;
                    end

        // R6: rejected configurations leave tiles untouched
        load_tiles(0);
        run_op(2'd3, 5, 16, 16, 1'b1, 1'b0);
        check_tiles(4, 4, 16, "R6 rows>max");
        run_op(2'd2, 4, 6, 16, 1'b1, 1'b0);
        check_tiles(4, 4, 16, "R6 a not mult4");
        run_op(2'd1, 4, 16, 20, 1'b1, 1'b0);
        check_tiles(4, 4, 16, "R6 c too wide");
        run_op(2'd0, 2, 20, 8, 1'b1, 1'b0);
        check_tiles(4, 4, 16, "R6 a too wide");

        // R8 / R2 / R9: restart, config and mode change and host write while busy
        for (int md = 0; md < 4; md++) begin
            load_tiles(1);
            run_op(2'(md), 3, 16, 12, 1'b0, 1'b1);
            model(2'(md), 3, 16, 12);
            check_tiles(3, 16, 12, "R8 disturbed");
        end

        finish_run();
    end

endmodule